// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Mode Fields

This block drives and samples sixteen general-purpose pins through a small register bus. The pins are grouped into four banks of unequal size: two, four, four and six pins. Each bank has two registers. The level register holds the value driven on output pins and returns the sampled level of input pins. The mode register gives every pin of the bank its own 4-bit mode code. A single drive-style register, shared by all banks, chooses for each pin whether an output is actively driven both ways or only pulls low (open-drain).

Software selects a mode per pin, writes levels and reads the pin state back. Pin inputs pass through a two-flop synchroniser before they can be read. Each pad gets a registered output value and a registered output-enable, which the surrounding pad ring turns into a tri-state buffer.

Top module: `bank_gpio_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released until the next write, every mode field, level bit and drive-style bit is 0. `pad_oe` is all zero and every register reads back 0 (with `pad_in` low).
- R2: Within bank b, pin i owns bits [4i+3:4i] of that bank's mode register (the first pin of the bank is i=0). A written field reads back unchanged.
- R3: A pin whose mode code is 0x8 and whose drive-style bit is 0 has `pad_oe`=1, and `pad_out` equals its level bit.
- R4: A pin whose mode code is anything other than 0x8 (0x1 = input, and every other code) has `pad_oe`=0 and `pad_out`=0.
- R5: When the drive-style bit n (register offset 0x190, bit n = pin n) is 1 and pin n has mode 0x8, the pin drives low (`pad_oe`=1, `pad_out`=0) when its level bit is 0 and is released (`pad_oe`=0) when the level bit is 1.
- R6: Reading a level register returns, for each pin, the stored level bit if the pin has mode 0x8, and the synchronised `pad_in` level otherwise. A write always stores the level bits.
- R7: The banks cover pins 0–1, 2–5, 6–9 and 10–15. Bank k (k = 0..3) has its level register at 0x170+4k and its mode register at 0x180+4k, and bit i of a level register is the bank's pin i.
- R8: Register bits beyond a bank's pin count, bits 31:16 of the drive-style register, and every unmapped address read as 0 and ignore writes.
- R9: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented. A write is seen by a read issued in the next cycle, not in the same cycle. `pad_out` and `pad_oe` follow a register write one clock after the register changes.
- R10: A change on `pad_in` reaches a level-register read only when the read is issued at least two cycles after the change. A read issued in the same cycle or in the next cycle returns the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 16 | Asynchronous pin levels from the pads |
| pad_out | output | 16 | Registered output value per pin |
| pad_oe | output | 16 | Registered output enable per pin (1 = drive) |

## Verification
Two pairs of events can land in the same clock. A bus write and a read of the same level register can share a cycle: the bench raises the write strobe while it issues the read of that address. It then expects the read to return the old contents and a read one cycle later to return the new value. A pin input can also change in the same cycle that a read of its bank is issued: the bench toggles `pad_in` together with the read and issues two more reads one and two cycles later. It expects the old level, the old level again, and then the new level, which shows that the two synchroniser stages and the read register are all in the path.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;
  localparam int NUM_PINS  = 16;
  localparam int NUM_BANKS = 4;
  localparam int MODE_W    = 4;
  localparam int BUS_W     = 32;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_IN  = 4'h1;
  localparam mode_t MODE_OUT = 4'h8;

  function automatic int bank_pins(input int b);
    case (b)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int bank_base(input int b);
    int s;
    s = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (k < b) s += bank_pins(k);
    return s;
  endfunction

  function automatic int max_bank_pins();
    int m;
    m = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (bank_pins(k) > m) m = bank_pins(k);
    return m;
  endfunction

  function automatic int pin_bank(input int p);
    int r;
    r = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (p >= bank_base(k)) r = k;
    return r;
  endfunction

  function automatic int pin_idx(input int p);
    return p - bank_base(pin_bank(p));
  endfunction
endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

  // Cycles since reset, saturating at 2; gates the latency check below.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R10: the synchronised value is the raw input from exactly two edges earlier
  assert_sync_depth_R10: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/bgpio_pad.sv
module bgpio_pad
  import bgpio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  lvl,
  input  logic  od,
  output logic  pad_out,
  output logic  pad_oe
);
  logic drive_en;
  assign drive_en = (mode == MODE_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= drive_en && !od && lvl;
      pad_oe  <= drive_en && (!od || !lvl);
    end
  end

  // R4: any code other than the output code leaves the pad released
  assert_released_R4: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_OUT) |=> (!pad_oe && !pad_out));

  // R3: push-pull output follows the level bit one cycle later
  assert_push_pull_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OUT && !od) |=> (pad_oe && (pad_out == $past(lvl))));

  // R5: open-drain output never drives high, enables only for a low level
  assert_open_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OUT && od) |=> (!pad_out && (pad_oe == !$past(lvl))));
endmodule

// File: rtl/bank_gpio_ctrl.sv
module bank_gpio_ctrl
  import bgpio_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [11:0]     LVL_BASE   = 12'h170,
  parameter logic [11:0]     MODE_BASE  = 12'h180,
  parameter logic [11:0]     STYLE_ADDR = 12'h190,
  parameter int              REG_STRIDE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int MODE_SPAN = MODE_W * max_bank_pins();
  localparam int B0_PINS   = bank_pins(0);

  function automatic logic [ADDR_W-1:0] lvl_addr(input int b);
    return ADDR_W'(LVL_BASE) + ADDR_W'(b * REG_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] mode_addr(input int b);
    return ADDR_W'(MODE_BASE) + ADDR_W'(b * REG_STRIDE);
  endfunction

  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] od_q;
  mode_t               mode_q [NUM_PINS];
  logic [NUM_PINS-1:0] pin_sync;
  logic [BUS_W-1:0]    rd_next;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:MODE_SPAN];

  // Register writes: each pin picks its bit/field from its own bank's word
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      od_q  <= '0;
      for (int p = 0; p < NUM_PINS; p++) mode_q[p] <= '0;
    end else if (bus_we) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_addr == lvl_addr(pin_bank(p)))
          lvl_q[p] <= bus_wdata[pin_idx(p)];
        if (bus_addr == mode_addr(pin_bank(p)))
          mode_q[p] <= bus_wdata[pin_idx(p)*MODE_W +: MODE_W];
      end
      if (bus_addr == ADDR_W'(STYLE_ADDR))
        od_q <= bus_wdata[NUM_PINS-1:0];
    end
  end

  bgpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (pin_sync)
  );

  // Read selection: addresses are disjoint, so at most one group fires
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == lvl_addr(pin_bank(p)))
        rd_next[pin_idx(p)] = (mode_q[p] == MODE_OUT) ? lvl_q[p] : pin_sync[p];
      if (bus_addr == mode_addr(pin_bank(p)))
        rd_next[pin_idx(p)*MODE_W +: MODE_W] = mode_q[p];
    end
    if (bus_addr == ADDR_W'(STYLE_ADDR))
      rd_next[NUM_PINS-1:0] = od_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    bgpio_pad u_pad (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_q[p]),
      .lvl     (lvl_q[p]),
      .od      (od_q[p]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p])
    );
  end

  // R8: bits above the first bank's pins read zero from its level register
  assert_bank0_pad_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == lvl_addr(0)) |=> (bus_rdata[BUS_W-1:B0_PINS] == '0));

  // R9: drive-style register read appears one cycle after its address
  assert_style_read_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(STYLE_ADDR)) |=>
      (bus_rdata == {{(BUS_W-NUM_PINS){1'b0}}, $past(od_q)}));

  // R2: a mode write to bank 3 is read back in place one cycle after it lands
  assert_mode_field_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == mode_addr(NUM_BANKS-1)) |=>
      (mode_q[NUM_PINS-1] == $past(bus_wdata[(bank_pins(NUM_BANKS-1)-1)*MODE_W +: MODE_W])));
endmodule

// File: tb/tb_bank_gpio_ctrl.sv
module tb_bank_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in;
  logic [15:0] pad_out;
  logic [15:0] pad_oe;

  always #5 clk = ~clk;

  bank_gpio_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Independent model of the register contents
  int          bb [4] = '{0, 2, 6, 10};
  int          bc [4] = '{2, 4, 4, 6};
  logic [15:0] m_lvl = '0;
  logic [15:0] m_od  = '0;
  logic [3:0]  m_mode [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] a_lvl(input int b);
    return 12'h170 + 12'(4 * b);
  endfunction
  function automatic logic [11:0] a_mode(input int b);
    return 12'h180 + 12'(4 * b);
  endfunction

  function automatic logic [31:0] exp_lvl(input int b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < bc[b]; i++)
      r[i] = (m_mode[bb[b]+i] == 4'h8) ? m_lvl[bb[b]+i] : pad_in[bb[b]+i];
    return r;
  endfunction

  function automatic logic [31:0] exp_mode(input int b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < bc[b]; i++) r[4*i +: 4] = m_mode[bb[b]+i];
    return r;
  endfunction

  // Scoreboard: driver pushes expectations, monitor pops when data is due
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        issue = 1'b0;
  logic        due   = 1'b0;

  always @(posedge clk) due <= issue;

  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    issue    = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    bus_addr  = a;
    bus_wdata = v;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_lvl(input int b, input logic [31:0] v);
    for (int i = 0; i < bc[b]; i++) m_lvl[bb[b]+i] = v[i];
    wr(a_lvl(b), v);
  endtask

  task automatic wr_mode(input int b, input logic [31:0] v);
    for (int i = 0; i < bc[b]; i++) m_mode[bb[b]+i] = v[4*i +: 4];
    wr(a_mode(b), v);
  endtask

  task automatic wr_style(input logic [31:0] v);
    m_od = v[15:0];
    wr(12'h190, v);
  endtask

  task automatic chk_pads(input string tag);
    logic [15:0] e_oe;
    logic [15:0] e_out;
    for (int p = 0; p < 16; p++) begin
      e_oe[p]  = (m_mode[p] == 4'h8) && (!m_od[p] || !m_lvl[p]);
      e_out[p] = (m_mode[p] == 4'h8) && !m_od[p] && m_lvl[p];
    end
    chk({tag, " pad_oe"},  {16'h0, pad_oe},  {16'h0, e_oe});
    chk({tag, " pad_out"}, {16'h0, pad_out}, {16'h0, e_out});
  endtask

  initial begin
    for (int p = 0; p < 16; p++) m_mode[p] = 4'h0;
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk_pads("R1 reset pads");
    for (int b = 0; b < 4; b++) rd(a_mode(b), 32'h0, "R1 reset mode reg");
    for (int b = 0; b < 4; b++) rd(a_lvl(b), 32'h0, "R1 reset level reg");
    rd(12'h190, 32'h0, "R1 reset style reg");

    // R2 / R8: field placement and masking of unused bits
    wr_mode(3, 32'hFF88_8888);
    rd(a_mode(3), 32'h0088_8888, "R2 R8 bank3 mode readback");
    wr_mode(0, 32'hFFFF_FF18);
    rd(a_mode(0), 32'h0000_0018, "R2 R8 bank0 mode readback");

    // R3 / R7: push-pull outputs on pins 10..15
    wr_lvl(3, 32'hFFFF_FFEA);
    @(negedge clk);
    chk_pads("R3 R7 bank3 push-pull");
    rd(a_lvl(3), 32'h0000_002A, "R6 R8 bank3 output latch read");

    // R9: pads follow one cycle after the register
    wr_lvl(3, 32'h0000_0015);
    chk("R9 pads not yet updated", {26'h0, pad_out[15:10]}, 32'h2A);
    @(negedge clk);
    chk("R9 pads updated", {26'h0, pad_out[15:10]}, 32'h15);

    // R6: pin0 output, pin1 input
    pad_in = 16'h0002;
    wr_lvl(0, 32'h1);
    repeat (3) @(negedge clk);
    rd(a_lvl(0), exp_lvl(0), "R6 mixed bank0 read");
    pad_in = 16'h0001;
    wr_lvl(0, 32'h0);
    repeat (3) @(negedge clk);
    rd(a_lvl(0), exp_lvl(0), "R6 output pin ignores pad");
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);

    // R4: codes other than 0x8 release the pad
    wr_mode(1, 32'h0000_3813);
    wr_lvl(1, 32'h0000_000F);
    @(negedge clk);
    chk_pads("R4 other codes undriven");

    // R5: open-drain on pins 4, 10, 11
    wr_style(32'hFFFF_0C10);
    rd(12'h190, 32'h0000_0C10, "R5 R8 style readback");
    chk_pads("R5 open-drain first levels");
    wr_lvl(3, 32'h0000_003E);
    @(negedge clk);
    chk_pads("R5 open-drain swapped levels");

    // R8: unmapped and misaligned addresses
    wr(12'h1A0, 32'hFFFF_FFFF);
    wr(12'h171, 32'hFFFF_FFFF);
    rd(12'h1A0, 32'h0, "R8 unmapped read");
    rd(12'h171, 32'h0, "R8 misaligned read");
    rd(a_mode(1), exp_mode(1), "R8 mode untouched");
    rd(a_lvl(3), exp_lvl(3), "R8 level untouched");
    chk_pads("R8 pads untouched");

    // R9: write and read of the same register in one cycle
    wr_mode(2, 32'h0000_8888);
    wr_lvl(2, 32'h5);
    rd(a_lvl(2), 32'h5, "R9 bank2 before");
    bus_wdata = 32'hA;
    bus_we    = 1'b1;
    for (int i = 0; i < 4; i++) m_lvl[6+i] = bus_wdata[i];
    rd(a_lvl(2), 32'h5, "R9 same-cycle read returns old");
    bus_we = 1'b0;
    rd(a_lvl(2), 32'hA, "R9 next-cycle read returns new");

    // R10: input latency through the synchroniser
    wr_mode(1, 32'h0000_0010);
    repeat (3) @(negedge clk);
    pad_in[3] = 1'b1;
    rd(a_lvl(1), 32'h0, "R10 same cycle old");
    rd(a_lvl(1), 32'h0, "R10 one cycle old");
    rd(a_lvl(1), 32'h2, "R10 two cycles new");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule